// File: doc/BRIEF.md
# Transmit Context Descriptor Tracker

This block sits after the transmit descriptor fetch and sees one serialized stream of descriptors that may come from either of two transmit queues. Each descriptor is either a context descriptor or a data descriptor. Both kinds carry a packet-type code and an end-of-packet flag. A context descriptor loads the single on-chip parameter set of its mode: extended or segmentation. Legacy needs no stored parameters. Both queues share these two register sets, and only the last written value of each is kept. A packet from one queue therefore uses whatever context the other queue wrote last.

For every data descriptor the block emits one output beat. The beat carries the resolved mode of the packet, the context parameters held for that mode (zero for legacy), the queue ID passed through, and a per-beat error mark. The block also tracks packet boundaries and checks the ordering of the stream. A context descriptor inside a packet is a violation. A change of packet type inside a packet is also a violation. Either case sets a sticky error flag, which only an explicit clear pulse resets. A descriptor that violates the rules is still processed: a context descriptor still loads its register, and a data descriptor is still emitted, with its error mark set.

The ordering checker is a two-state machine:
- ST_BOUNDARY: between packets.
- ST_IN_PKT: inside a packet; the packet's type is locked.

It has three transitions:
- open packet: ST_BOUNDARY to ST_IN_PKT, on a data descriptor without the end flag.
- close packet: ST_IN_PKT to ST_BOUNDARY, on a data descriptor with the end flag.
- stay: any other accepted descriptor leaves the state unchanged.

Top module: `txctx_tracker`

## Requirements
- R1: After reset:
  - out_valid and err_flag are 0 and in_ready is 1.
  - Both context registers hold zero, so a data descriptor of type extended (code 2'b01) or segmentation (code 2'b10) reports a context of zero.
  - The block is at a packet boundary, so a leading context descriptor is legal.
- R2: A context descriptor (in_is_ctx=1) with type extended (2'b01) or segmentation (2'b10), accepted at a boundary, replaces that mode's register and leaves the other mode's register unchanged.
- R3: A data descriptor of type legacy (2'b00) reports out_mode 2'b00 and out_ctx zero.
- R4: A loaded context value applies to every later packet of its mode until another context descriptor of that mode overwrites it.
- R5: The context registers are shared by both queues. A value written with in_qid=1 is reported for packets with in_qid=0, and the reverse holds too. out_qid equals the in_qid of the data descriptor.
- R6: A context descriptor accepted inside a packet sets err_flag. The descriptor still loads its register, and the packet stays open.
- R7: Inside a packet, the mode is locked to the type of the packet's first descriptor. A data descriptor whose type code differs from the locked type is emitted with out_err=1 and the locked mode, and it sets err_flag.
- R8: A type change between packets, that is, after a descriptor with in_eop=1, is legal. It gives out_err=0 and leaves err_flag unchanged.
- R9: Type code 2'b11 is reserved, and so is code 2'b00 on a context descriptor.
  - A reserved context descriptor sets err_flag and loads nothing.
  - A reserved data descriptor is emitted as legacy with out_err=1.
- R10: err_flag stays set until a cycle with err_clr=1. If err_clr=1 and a violating descriptor is accepted in the same cycle, the flag stays set.
- R11: While out_valid=1 and out_ready=0, in_ready is 0 and all output fields hold their values.
- R12: A data descriptor accepted at a clock edge appears on the outputs (out_valid=1) right after that edge. Context descriptors produce no output beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor present |
| in_ready | output | 1 | Block can accept a descriptor |
| in_qid | input | 1 | Source queue of the descriptor |
| in_is_ctx | input | 1 | 1 = context descriptor, 0 = data descriptor |
| in_ptype | input | 2 | Packet type: 00 legacy, 01 extended, 10 segmentation, 11 reserved |
| in_eop | input | 1 | Last data descriptor of a packet |
| in_ctx | input | CTX_W | Context parameters carried by a context descriptor |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_qid | output | 1 | Queue ID of the data descriptor |
| out_mode | output | 2 | Resolved mode of the packet |
| out_ctx | output | CTX_W | Context parameters applying to the beat |
| out_err | output | 1 | Beat came from a violating descriptor |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky ordering-violation flag |

## Verification
A wrong boundary state shows on the first data descriptor that follows it. Either a legal type change at a packet start raises out_err, or a mixed-type packet slips through without one. A stray context write shows only when the next data beat of that mode reports the wrong out_ctx, and that may be several packets later. The tests therefore follow every context load with data beats of both modes. A wrong locked type also shows as a wrong out_mode on the very next beat of the same packet.

// File: rtl/txctx_pkg.sv
package txctx_pkg;

    typedef enum logic [1:0] {
        PT_LEGACY = 2'b00,
        PT_EXT    = 2'b01,
        PT_SEG    = 2'b10,
        PT_RSVD   = 2'b11
    } ptype_e;

    typedef enum logic {
        ST_BOUNDARY = 1'b0,
        ST_IN_PKT   = 1'b1
    } ord_state_e;

    localparam int NUM_CTX_BANKS = 2;
    localparam int BANK_EXT      = 0;
    localparam int BANK_SEG      = 1;

endpackage

// File: rtl/txctx_order_fsm.sv
module txctx_order_fsm
    import txctx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic       is_ctx,
    input  logic [1:0] ptype,
    input  logic       eop,
    output logic       viol,
    output logic [1:0] mode,
    output logic [NUM_CTX_BANKS-1:0] ctx_load
);

    ord_state_e state_q, state_d;
    ptype_e     lock_q, lock_d;
    ptype_e     pt_in;
    ptype_e     pt_resolved;
    logic [NUM_CTX_BANKS-1:0] ld_sel;

    assign pt_in       = ptype_e'(ptype);
    assign pt_resolved = (pt_in == PT_RSVD) ? PT_LEGACY : pt_in;

    // Which bank a context descriptor targets; none for reserved codes
    always_comb begin
        ld_sel = '0;
        unique case (pt_in)
            PT_EXT:  ld_sel[BANK_EXT] = 1'b1;
            PT_SEG:  ld_sel[BANK_SEG] = 1'b1;
            default: ld_sel = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOUNDARY;
            lock_q  <= PT_LEGACY;
        end else begin
            state_q <= state_d;
            lock_q  <= lock_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        lock_d   = lock_q;
        viol     = 1'b0;
        mode     = PT_LEGACY;
        ctx_load = '0;
        unique case (state_q)
            ST_BOUNDARY: begin
                if (is_ctx) begin
                    viol     = (ld_sel == '0);
                    ctx_load = fire ? ld_sel : '0;
                end else begin
                    mode = pt_resolved;
                    viol = (pt_in == PT_RSVD);
                    if (fire && !eop) begin
                        state_d = ST_IN_PKT;      // open packet
                        lock_d  = pt_resolved;
                    end
                end
            end
            ST_IN_PKT: begin
                if (is_ctx) begin
                    viol     = 1'b1;
                    ctx_load = fire ? ld_sel : '0;
                end else begin
                    mode = lock_q;
                    viol = (pt_in != lock_q);
                    if (fire && eop) begin
                        state_d = ST_BOUNDARY;    // close packet
                    end
                end
            end
            default: begin
                state_d = ST_BOUNDARY;
            end
        endcase
    end

endmodule

// File: rtl/txctx_ctx_store.sv
module txctx_ctx_store
    import txctx_pkg::*;
#(
    parameter int CTX_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CTX_BANKS-1:0] load,
    input  logic [CTX_W-1:0]         wdata,
    input  logic [1:0]               rd_mode,
    output logic [CTX_W-1:0]         rdata
);

    logic [CTX_W-1:0] bank_q [NUM_CTX_BANKS];

    for (genvar g = 0; g < NUM_CTX_BANKS; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (load[g]) begin
                bank_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        unique case (ptype_e'(rd_mode))
            PT_EXT:  rdata = bank_q[BANK_EXT];
            PT_SEG:  rdata = bank_q[BANK_SEG];
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/txctx_out_stage.sv
module txctx_out_stage #(
    parameter int CTX_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             qid_in,
    input  logic [1:0]       mode_in,
    input  logic [CTX_W-1:0] ctx_in,
    input  logic             err_in,
    input  logic             out_ready,
    output logic             out_valid,
    output logic             out_qid,
    output logic [1:0]       out_mode,
    output logic [CTX_W-1:0] out_ctx,
    output logic             out_err
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_qid   <= 1'b0;
            out_mode  <= '0;
            out_ctx   <= '0;
            out_err   <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_qid   <= qid_in;
            out_mode  <= mode_in;
            out_ctx   <= ctx_in;
            out_err   <= err_in;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/txctx_err_flag.sv
module txctx_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/txctx_tracker.sv
module txctx_tracker
    import txctx_pkg::*;
#(
    parameter int CTX_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_qid,
    input  logic             in_is_ctx,
    input  logic [1:0]       in_ptype,
    input  logic             in_eop,
    input  logic [CTX_W-1:0] in_ctx,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_qid,
    output logic [1:0]       out_mode,
    output logic [CTX_W-1:0] out_ctx,
    output logic             out_err,
    input  logic             err_clr,
    output logic             err_flag
);

    logic                     fire;
    logic                     viol;
    logic [1:0]               mode;
    logic [NUM_CTX_BANKS-1:0] ctx_load;
    logic [CTX_W-1:0]         ctx_rd;

    assign in_ready = !out_valid || out_ready;
    assign fire     = in_valid && in_ready;

    txctx_order_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .is_ctx   (in_is_ctx),
        .ptype    (in_ptype),
        .eop      (in_eop),
        .viol     (viol),
        .mode     (mode),
        .ctx_load (ctx_load)
    );

    txctx_ctx_store #(.CTX_W(CTX_W)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ctx_load),
        .wdata   (in_ctx),
        .rd_mode (mode),
        .rdata   (ctx_rd)
    );

    txctx_out_stage #(.CTX_W(CTX_W)) i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (fire && !in_is_ctx),
        .qid_in    (in_qid),
        .mode_in   (mode),
        .ctx_in    (ctx_rd),
        .err_in    (viol),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_qid   (out_qid),
        .out_mode  (out_mode),
        .out_ctx   (out_ctx),
        .out_err   (out_err)
    );

    txctx_err_flag i_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fire && viol),
        .clr   (err_clr),
        .flag  (err_flag)
    );

endmodule

// File: rtl/txctx_tracker_chk.sv
module txctx_tracker_chk #(
    parameter int CTX_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_is_ctx,
    input logic             in_eop,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_qid,
    input logic [1:0]       out_mode,
    input logic [CTX_W-1:0] out_ctx,
    input logic             out_err,
    input logic             err_clr,
    input logic             err_flag
);

    logic acc;
    logic mid_pkt;
    logic new_beat;

    assign acc = in_valid && in_ready;

    // Independent packet-boundary model from the port stream
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_pkt  <= 1'b0;
            new_beat <= 1'b0;
        end else begin
            new_beat <= acc && !in_is_ctx;
            if (acc && !in_is_ctx) begin
                mid_pkt <= !in_eop;
            end
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_mode) && $stable(out_ctx) && $stable(out_qid) && $stable(out_err)); // R11

    AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> !new_beat); // R11

    AST_LEGACY_ZERO_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_mode == 2'b00 |-> out_ctx == '0); // R3

    AST_MIDPKT_CTX_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        acc && in_is_ctx && mid_pkt |=> err_flag); // R6

    AST_ERR_BEAT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && new_beat && out_err |-> err_flag); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !err_clr |=> err_flag); // R10

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !acc |=> !err_flag); // R10

    AST_BEAT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !in_is_ctx |=> out_valid); // R12

endmodule

bind txctx_tracker txctx_tracker_chk #(.CTX_W(CTX_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_is_ctx (in_is_ctx),
    .in_eop    (in_eop),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_qid   (out_qid),
    .out_mode  (out_mode),
    .out_ctx   (out_ctx),
    .out_err   (out_err),
    .err_clr   (err_clr),
    .err_flag  (err_flag)
);

// File: tb/test_txctx_tracker.sv
`timescale 1ns/1ps
module test_txctx_tracker;

    localparam int CTX_W = 32;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic             in_ready;
    logic             in_qid;
    logic             in_is_ctx;
    logic [1:0]       in_ptype;
    logic             in_eop;
    logic [CTX_W-1:0] in_ctx;
    logic             out_valid;
    logic             out_ready;
    logic             out_qid;
    logic [1:0]       out_mode;
    logic [CTX_W-1:0] out_ctx;
    logic             out_err;
    logic             err_clr;
    logic             err_flag;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    txctx_tracker #(.CTX_W(CTX_W)) i_txctx_tracker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_qid(in_qid), .in_is_ctx(in_is_ctx), .in_ptype(in_ptype), .in_eop(in_eop),
        .in_ctx(in_ctx), .out_valid(out_valid), .out_ready(out_ready), .out_qid(out_qid),
        .out_mode(out_mode), .out_ctx(out_ctx), .out_err(out_err),
        .err_clr(err_clr), .err_flag(err_flag)
    );

    typedef struct packed {
        logic        is_ctx;
        logic        qid;
        logic [1:0]  pt;
        logic        eop;
        logic [31:0] ctx;
        logic        exp_out;
        logic [1:0]  exp_mode;
        logic [31:0] exp_ctx;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 2'b00, 1'b1, 32'h0,          1'b1, 2'b00, 32'h0},          // R3 legacy
        '{1'b0, 1'b0, 2'b01, 1'b1, 32'h0,          1'b1, 2'b01, 32'h0},          // R1 ext ctx zero
        '{1'b1, 1'b1, 2'b01, 1'b0, 32'hA5A5_0001,  1'b0, 2'b00, 32'h0},          // R2 ext load q1
        '{1'b1, 1'b0, 2'b10, 1'b0, 32'h0000_BEEF,  1'b0, 2'b00, 32'h0},          // R2 seg load q0
        '{1'b0, 1'b0, 2'b01, 1'b0, 32'h0,          1'b1, 2'b01, 32'hA5A5_0001},  // R5 shared
        '{1'b0, 1'b0, 2'b01, 1'b1, 32'h0,          1'b1, 2'b01, 32'hA5A5_0001},
        '{1'b0, 1'b1, 2'b10, 1'b1, 32'h0,          1'b1, 2'b10, 32'h0000_BEEF},  // R2 seg
        '{1'b0, 1'b1, 2'b01, 1'b1, 32'h0,          1'b1, 2'b01, 32'hA5A5_0001},  // R4 persist
        '{1'b0, 1'b0, 2'b00, 1'b0, 32'h0,          1'b1, 2'b00, 32'h0},          // R8
        '{1'b0, 1'b0, 2'b00, 1'b1, 32'h0,          1'b1, 2'b00, 32'h0},
        '{1'b0, 1'b1, 2'b10, 1'b1, 32'h0,          1'b1, 2'b10, 32'h0000_BEEF},  // R8 change at boundary
        '{1'b1, 1'b0, 2'b01, 1'b0, 32'h1234_5678,  1'b0, 2'b00, 32'h0},          // R2 overwrite
        '{1'b0, 1'b1, 2'b01, 1'b1, 32'h0,          1'b1, 2'b01, 32'h1234_5678}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one descriptor; returns at the negedge after it was accepted
    task automatic send(input logic c, input logic q, input logic [1:0] pt,
                        input logic e, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_is_ctx = c; in_qid = q; in_ptype = pt; in_eop = e; in_ctx = d;
        @(posedge clk);
        while (!in_ready) @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_qid = 1'b0; in_is_ctx = 1'b0;
        in_ptype = 2'b00; in_eop = 1'b0; in_ctx = '0; out_ready = 1'b1; err_clr = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        chk("R1 err_flag", 64'(err_flag), 64'd0);
        chk("R1 in_ready", 64'(in_ready), 64'd1);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            send(VECS[i].is_ctx, VECS[i].qid, VECS[i].pt, VECS[i].eop, VECS[i].ctx);
            chk($sformatf("R12 vec%0d out_valid", i), 64'(out_valid), 64'(VECS[i].exp_out));
            if (VECS[i].exp_out) begin
                chk($sformatf("R2/R4 vec%0d mode", i), 64'(out_mode), 64'(VECS[i].exp_mode));
                chk($sformatf("R2/R4 vec%0d ctx", i), 64'(out_ctx), 64'(VECS[i].exp_ctx));
                chk($sformatf("R5 vec%0d qid", i), 64'(out_qid), 64'(VECS[i].qid));
                chk($sformatf("R8 vec%0d out_err", i), 64'(out_err), 64'd0);
            end
            chk($sformatf("R8 vec%0d err_flag", i), 64'(err_flag), 64'd0);
        end

        // R7: type change inside a packet
        send(1'b0, 1'b0, 2'b01, 1'b0, 32'h0);
        chk("R7 first out_err", 64'(out_err), 64'd0);
        send(1'b0, 1'b0, 2'b10, 1'b1, 32'h0);
        chk("R7 out_err", 64'(out_err), 64'd1);
        chk("R7 locked mode", 64'(out_mode), 64'd1);
        chk("R7 err_flag", 64'(err_flag), 64'd1);
        send(1'b0, 1'b1, 2'b00, 1'b1, 32'h0);
        chk("R10 legal beat out_err", 64'(out_err), 64'd0);
        chk("R10 flag sticky", 64'(err_flag), 64'd1);
        pulse_clr();
        chk("R10 cleared", 64'(err_flag), 64'd0);

        // R6: context inside a packet still loads
        send(1'b0, 1'b0, 2'b10, 1'b0, 32'h0);
        send(1'b1, 1'b1, 2'b01, 1'b0, 32'h0000_0777);
        chk("R6 err_flag", 64'(err_flag), 64'd1);
        send(1'b0, 1'b0, 2'b10, 1'b1, 32'h0);
        chk("R6 packet stays open mode", 64'(out_mode), 64'd2);
        chk("R6 seg ctx unchanged", 64'(out_ctx), 64'h0000_BEEF);
        chk("R6 close beat out_err", 64'(out_err), 64'd0);
        send(1'b0, 1'b0, 2'b01, 1'b1, 32'h0);
        chk("R6 ext loaded", 64'(out_ctx), 64'h0000_0777);
        pulse_clr();

        // R9: reserved codes
        send(1'b0, 1'b1, 2'b11, 1'b1, 32'h0);
        chk("R9 reserved data mode", 64'(out_mode), 64'd0);
        chk("R9 reserved data out_err", 64'(out_err), 64'd1);
        chk("R9 reserved data ctx", 64'(out_ctx), 64'd0);
        pulse_clr();
        send(1'b1, 1'b0, 2'b11, 1'b0, 32'hDEAD_0000);
        chk("R9 reserved ctx flag", 64'(err_flag), 64'd1);
        pulse_clr();
        send(1'b1, 1'b0, 2'b00, 1'b0, 32'hDEAD_0001);
        chk("R9 legacy ctx flag", 64'(err_flag), 64'd1);
        pulse_clr();
        send(1'b0, 1'b0, 2'b01, 1'b1, 32'h0);
        chk("R9 ext not loaded", 64'(out_ctx), 64'h0000_0777);
        send(1'b0, 1'b0, 2'b10, 1'b1, 32'h0);
        chk("R9 seg not loaded", 64'(out_ctx), 64'h0000_BEEF);
        chk("R9 flag after clear", 64'(err_flag), 64'd0);

        // R10: set wins over clear
        send(1'b0, 1'b0, 2'b01, 1'b0, 32'h0);
        @(negedge clk);
        in_valid = 1'b1; in_is_ctx = 1'b1; in_ptype = 2'b10; in_ctx = 32'h0000_BEEF; err_clr = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; err_clr = 1'b0;
        chk("R10 set wins", 64'(err_flag), 64'd1);
        send(1'b0, 1'b0, 2'b01, 1'b1, 32'h0);
        pulse_clr();

        // R11: backpressure
        @(negedge clk);
        out_ready = 1'b0;
        send(1'b0, 1'b1, 2'b10, 1'b1, 32'h0);
        chk("R11 beat present", 64'(out_valid), 64'd1);
        @(negedge clk);
        in_valid = 1'b1; in_is_ctx = 1'b0; in_qid = 1'b0; in_ptype = 2'b00; in_eop = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 in_ready low", 64'(in_ready), 64'd0);
        chk("R11 mode held", 64'(out_mode), 64'd2);
        chk("R11 qid held", 64'(out_qid), 64'd1);
        chk("R11 ctx held", 64'(out_ctx), 64'h0000_BEEF);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11 next beat mode", 64'(out_mode), 64'd0);
        chk("R11 next beat qid", 64'(out_qid), 64'd0);
        @(negedge clk);
        chk("R12 beat drained", 64'(out_valid), 64'd0);

        summary();
        $finish;
    end

endmodule